// File: doc/BRIEF.md
# Folded Symmetric Decimating FIR Engine

This block is a time-multiplexed FIR filter for I/Q sample streams. It runs on a compute clock that is much faster than the sample rate. A two-lane multiply-accumulate unit, one lane for I and one for Q, walks the tap set one step per clock. Samples enter a delay line through a valid/ready input. After every R accepted samples the engine computes one output pair and presents it with a single-cycle valid strobe.

For filters with mirrored coefficients, the two delay-line samples that share a coefficient are summed, or differenced for anti-symmetry, before the multiply. Each step then covers two taps. Asymmetric real filters use one tap per step. Complex filters use two steps per tap: one for the in-phase coefficient and one for the quadrature coefficient.

Coefficients are written through an address/data port into a 128-entry store. Mode, tap count, decimation and output shift are taken from configuration pins only while the engine is idle.

Top module: `fir_fold_decim`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, both outputs are 0, and every delay-line entry is 0, so samples older than the first accepted one count as zero.
- R2: With `cfg_mode` = 0 (asymmetric real), coefficient address k holds h(k) for k < N. Each output lane is the sum over t < N of h(t)·x(n−t), where x(n) is the newest sample. The same coefficients apply to I and Q.
- R3: With `cfg_mode` = 1 (mirror-symmetric), let M = floor(N/2). Address j holds h(M+j), and h(N−1−M−j) equals the same value. For odd N, address 0 is the centre tap, which is used once with no partner. For even N, the two middle taps share address 0.
- R4: With `cfg_mode` = 2 (anti-symmetric), addressing is as in R3, but the mirrored tap is the negated value. For odd N, the centre tap uses address 0 alone with no negation.
- R5: With `cfg_mode` = 3 (complex, N ≤ 64), address t holds the in-phase coefficient cI(t) and address 64+t holds the quadrature coefficient cQ(t). The I output is Σ cI·xI − cQ·xQ and the Q output is Σ cI·xQ + cQ·xI.
- R6: With `cfg_decim` = R (1 to 16), exactly one output is produced per R accepted samples. It is computed with the R-th sample as the newest delay-line entry.
- R7: `in_ready` drops in the cycle after the R-th sample is accepted and stays low until the output strobe. Configuration changes made while `in_ready` is low have no effect on that output.
- R8: Each output is the full-precision sum, arithmetically shifted right by `cfg_shift`, then clamped to the signed `OUT_W`-bit range.
- R9: With coefficient h(0) = 1, every other used coefficient 0 and shift 0, every output equals the newest input sample (pass-through).
- R10: `out_valid` is high for exactly one cycle per output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Compute clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Engine can accept a sample |
| in_i | input | SAMP_W | In-phase sample, signed |
| in_q | input | SAMP_W | Quadrature sample, signed |
| cfg_mode | input | 2 | 0 asymmetric, 1 symmetric, 2 anti-symmetric, 3 complex |
| cfg_taps | input | TAP_W | Tap count N |
| cfg_decim | input | DEC_W | Decimation rate R |
| cfg_shift | input | SH_W | Right shift applied before clamping |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | CADDR_W | Coefficient address |
| coef_wdata | input | COEF_W | Coefficient value, signed |
| out_valid | output | 1 | One-cycle output strobe |
| out_i | output | OUT_W | In-phase result, signed |
| out_q | output | OUT_W | Quadrature result, signed |

## Verification
The hardest case to reach from the ports is a configuration change that lands while a computation is running. The engine never reveals its latched copy of the configuration, so the effect can only be inferred from a later output. The bench therefore waits for `in_ready` to fall after the R-th sample. It then alters the shift and tap count, and expects the output built from the old values. It restores the settings in the same cycle the strobe is seen, so that no altered value reaches an idle cycle.

Odd tap counts in both symmetric modes stress the unpaired centre step. Directed cases at N = 255 and N = 64 complex fill the coefficient store to its limits, and seeded random configurations cover the rest.

// File: rtl/fir_fold_pkg.sv
// Package: shared mode and state encodings for the folded FIR engine.
// Assumes: mode codes are fixed by the port contract (0..3).
package fir_fold_pkg;

    typedef enum logic [1:0] {
        MODE_ASYM     = 2'd0,
        MODE_SYM_EVEN = 2'd1,
        MODE_SYM_ODD  = 2'd2,
        MODE_CPLX     = 2'd3
    } fir_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_OUT  = 2'd2
    } fir_state_e;

endpackage

// File: rtl/fir_coef_store.sv
// Coefficient store: synchronous write, combinational read.
// Assumes: entries never written are never read by a legal configuration,
// so the array carries no reset.
module fir_coef_store #(
    parameter int DEPTH   = 128,
    parameter int COEF_W  = 22,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic signed [COEF_W-1:0] wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic signed [COEF_W-1:0] rdata
);

    logic signed [COEF_W-1:0] mem [DEPTH];

    // Store a coefficient on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fir_tap_line.sv
// Tap line: I/Q shift register with two random read ports.
// Assumes: an index at or beyond DEPTH reads as zero.
module fir_tap_line #(
    parameter int SAMP_W = 12,
    parameter int DEPTH  = 255,
    parameter int IDX_W  = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic signed [SAMP_W-1:0] din_i,
    input  logic signed [SAMP_W-1:0] din_q,
    input  logic [IDX_W-1:0]         idx_a,
    input  logic [IDX_W-1:0]         idx_b,
    output logic signed [SAMP_W-1:0] a_i,
    output logic signed [SAMP_W-1:0] a_q,
    output logic signed [SAMP_W-1:0] b_i,
    output logic signed [SAMP_W-1:0] b_q,
    output logic signed [SAMP_W-1:0] head_i,
    output logic signed [SAMP_W-1:0] head_q
);

    localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic signed [SAMP_W-1:0] line_i [DEPTH];
    logic signed [SAMP_W-1:0] line_q [DEPTH];

    // Stage 0 takes the accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_i[0] <= '0;
            line_q[0] <= '0;
        end else if (shift_en) begin
            line_i[0] <= din_i;
            line_q[0] <= din_q;
        end
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        // Each later stage takes its predecessor on a shift.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_i[k] <= '0;
                line_q[k] <= '0;
            end else if (shift_en) begin
                line_i[k] <= line_i[k-1];
                line_q[k] <= line_q[k-1];
            end
        end
    end

    // Read port A, zero beyond the line.
    always_comb begin
        a_i = '0;
        a_q = '0;
        if (idx_a < IDX_W'(DEPTH)) begin
            a_i = line_i[idx_a[SEL_W-1:0]];
            a_q = line_q[idx_a[SEL_W-1:0]];
        end
    end

    // Read port B, zero beyond the line.
    always_comb begin
        b_i = '0;
        b_q = '0;
        if (idx_b < IDX_W'(DEPTH)) begin
            b_i = line_i[idx_b[SEL_W-1:0]];
            b_q = line_q[idx_b[SEL_W-1:0]];
        end
    end

    assign head_i = line_i[0];
    assign head_q = line_q[0];

endmodule

// File: rtl/fir_sequencer.sv
// Sequencer: counts accepted samples, latches configuration while idle,
// and walks the MAC steps, producing the coefficient address, the tap
// indices and the fold control for each step.
// Assumes: the tap count and mode are legal (N <= 128 asymmetric,
// N <= 255 symmetric, N <= 64 complex).
module fir_sequencer
    import fir_fold_pkg::*;
#(
    parameter int TAP_W   = 8,
    parameter int DEC_W   = 5,
    parameter int SH_W    = 6,
    parameter int CADDR_W = 7,
    parameter int STEP_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         cfg_mode,
    input  logic [TAP_W-1:0]   cfg_taps,
    input  logic [DEC_W-1:0]   cfg_decim,
    input  logic [SH_W-1:0]    cfg_shift,
    output logic               in_ready,
    output logic               busy,
    output logic               shift_en,
    output logic               mac_clear,
    output logic               mac_en,
    output logic               out_load,
    output logic [CADDR_W-1:0] coef_raddr,
    output logic [STEP_W-1:0]  idx_a,
    output logic [STEP_W-1:0]  idx_b,
    output logic               use_b,
    output logic               sub_b,
    output logic               cplx_ph,
    output logic [SH_W-1:0]    lat_shift,
    output logic [DEC_W-1:0]   lat_decim
);

    localparam logic [STEP_W-1:0]  ONE_S = STEP_W'(1);
    localparam logic [DEC_W:0]     ONE_D = (DEC_W+1)'(1);
    localparam logic [CADDR_W-1:0] QOFF  = CADDR_W'(1 << (CADDR_W-1));

    fir_state_e         state_q;
    fir_mode_e          lat_mode;
    logic [TAP_W-1:0]   lat_taps;
    logic [DEC_W-1:0]   dec_cnt;
    logic [STEP_W-1:0]  step_q;
    logic [STEP_W-1:0]  steps;
    logic [STEP_W-1:0]  half;
    logic [STEP_W-1:0]  tap;
    logic               fire;
    logic               group_end;
    logic               last_step;

    assign in_ready  = (state_q == ST_IDLE);
    assign busy      = (state_q != ST_IDLE);
    assign fire      = in_valid && in_ready;
    assign shift_en  = fire;
    assign group_end = (({1'b0, dec_cnt} + ONE_D) >= {1'b0, lat_decim});
    assign mac_clear = fire && group_end;
    assign mac_en    = (state_q == ST_RUN);
    assign out_load  = (state_q == ST_OUT);
    assign half      = STEP_W'(lat_taps >> 1);
    assign tap       = step_q >> 1;

    // Number of MAC steps for the latched mode and tap count (at least 1).
    always_comb begin
        unique case (lat_mode)
            MODE_ASYM:                steps = STEP_W'(lat_taps);
            MODE_SYM_EVEN,
            MODE_SYM_ODD:             steps = STEP_W'(({1'b0, lat_taps} + 1'b1) >> 1);
            default:                  steps = {lat_taps, 1'b0};
        endcase
        if (steps == '0) begin
            steps = ONE_S;
        end
    end

    assign last_step = (step_q == (steps - ONE_S));

    // Per-step coefficient address, tap indices and fold control.
    always_comb begin
        coef_raddr = CADDR_W'(step_q);
        idx_a      = step_q;
        idx_b      = '0;
        use_b      = 1'b0;
        sub_b      = 1'b0;
        cplx_ph    = 1'b0;
        unique case (lat_mode)
            MODE_SYM_EVEN, MODE_SYM_ODD: begin
                idx_a = half + step_q;
                sub_b = (lat_mode == MODE_SYM_ODD);
                if (lat_taps[0]) begin
                    idx_b = half - step_q;
                    use_b = (step_q != '0);
                end else begin
                    idx_b = half - ONE_S - step_q;
                    use_b = 1'b1;
                end
            end
            MODE_CPLX: begin
                cplx_ph    = step_q[0];
                idx_a      = tap;
                coef_raddr = step_q[0] ? (QOFF + CADDR_W'(tap)) : CADDR_W'(tap);
            end
            default: begin
            end
        endcase
    end

    // Configuration latch: follows the pins only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_mode  <= MODE_ASYM;
            lat_taps  <= TAP_W'(1);
            lat_decim <= DEC_W'(1);
            lat_shift <= '0;
        end else if (state_q == ST_IDLE) begin
            lat_mode  <= fir_mode_e'(cfg_mode);
            lat_taps  <= cfg_taps;
            lat_decim <= cfg_decim;
            lat_shift <= cfg_shift;
        end
    end

    // Decimation phase counter and compute state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dec_cnt <= '0;
            step_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (fire) begin
                        if (group_end) begin
                            dec_cnt <= '0;
                            step_q  <= '0;
                            state_q <= ST_RUN;
                        end else begin
                            dec_cnt <= dec_cnt + DEC_W'(1);
                        end
                    end
                end
                ST_RUN: begin
                    step_q <= step_q + ONE_S;
                    if (last_step) begin
                        state_q <= ST_OUT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fir_mac_sat.sv
// MAC and output stage: two-lane pre-add/multiply/accumulate, followed by
// shift and clamp into registered outputs.
// Assumes: clear and en are never high together; load comes one cycle
// after the last en.
module fir_mac_sat #(
    parameter int SAMP_W = 12,
    parameter int COEF_W = 22,
    parameter int ACC_W  = 44,
    parameter int OUT_W  = 16,
    parameter int SH_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     en,
    input  logic                     load,
    input  logic                     use_b,
    input  logic                     sub_b,
    input  logic                     cplx_ph,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [SAMP_W-1:0] a_i,
    input  logic signed [SAMP_W-1:0] a_q,
    input  logic signed [SAMP_W-1:0] b_i,
    input  logic signed [SAMP_W-1:0] b_q,
    input  logic [SH_W-1:0]          shift,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_i,
    output logic signed [OUT_W-1:0]  out_q
);

    localparam int PRE_W  = SAMP_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;
    localparam logic signed [ACC_W-1:0] SAT_HI =
        {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_LO =
        {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [PRE_W-1:0]  ai_x, aq_x, bi_x, bq_x;
    logic signed [PRE_W-1:0]  pre_i, pre_q, op_i, op_q;
    logic signed [PROD_W-1:0] prod_i, prod_q;
    logic signed [ACC_W-1:0]  acc_i, acc_q, sh_i, sh_q;

    assign ai_x = PRE_W'(a_i);
    assign aq_x = PRE_W'(a_q);
    assign bi_x = PRE_W'(b_i);
    assign bq_x = PRE_W'(b_q);

    // Fold the mirrored sample in by sum or difference.
    always_comb begin
        pre_i = ai_x;
        pre_q = aq_x;
        if (use_b) begin
            pre_i = sub_b ? (ai_x - bi_x) : (ai_x + bi_x);
            pre_q = sub_b ? (aq_x - bq_x) : (aq_x + bq_x);
        end
    end

    // Quadrature step of a complex tap swaps lanes and negates one.
    assign op_i   = cplx_ph ? -aq_x : pre_i;
    assign op_q   = cplx_ph ? ai_x  : pre_q;
    assign prod_i = PROD_W'(op_i) * PROD_W'(coef);
    assign prod_q = PROD_W'(op_q) * PROD_W'(coef);

    // Accumulate one step per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_i <= '0;
            acc_q <= '0;
        end else if (en) begin
            acc_i <= acc_i + ACC_W'(prod_i);
            acc_q <= acc_q + ACC_W'(prod_q);
        end
    end

    assign sh_i = acc_i >>> shift;
    assign sh_q = acc_q >>> shift;

    function automatic logic signed [OUT_W-1:0] clip(input logic signed [ACC_W-1:0] v);
        if (v > SAT_HI) begin
            return SAT_HI[OUT_W-1:0];
        end else if (v < SAT_LO) begin
            return SAT_LO[OUT_W-1:0];
        end
        return v[OUT_W-1:0];
    endfunction

    // Register the clamped result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= load;
            if (load) begin
                out_i <= clip(sh_i);
                out_q <= clip(sh_q);
            end
        end
    end

endmodule

// File: rtl/fir_fold_decim.sv
// Top of the folded decimating FIR engine: ties the sequencer, the tap
// line, the coefficient store and the MAC together.
// Assumes: configuration is legal when the engine is idle; coefficient
// writes happen while idle.
module fir_fold_decim #(
    parameter int SAMP_W     = 12,
    parameter int COEF_W     = 22,
    parameter int COEF_DEPTH = 128,
    parameter int MAX_TAPS   = 255,
    parameter int MAX_DECIM  = 16,
    parameter int OUT_W      = 16,
    localparam int TAP_W     = $clog2(MAX_TAPS + 1),
    localparam int DEC_W     = $clog2(MAX_DECIM + 1),
    localparam int CADDR_W   = $clog2(COEF_DEPTH),
    localparam int STEP_W    = TAP_W + 1,
    localparam int ACC_W     = SAMP_W + 1 + COEF_W + TAP_W + 1,
    localparam int SH_W      = $clog2(ACC_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [SAMP_W-1:0]  in_i,
    input  logic [SAMP_W-1:0]  in_q,
    input  logic [1:0]         cfg_mode,
    input  logic [TAP_W-1:0]   cfg_taps,
    input  logic [DEC_W-1:0]   cfg_decim,
    input  logic [SH_W-1:0]    cfg_shift,
    input  logic               coef_we,
    input  logic [CADDR_W-1:0] coef_addr,
    input  logic [COEF_W-1:0]  coef_wdata,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_i,
    output logic [OUT_W-1:0]   out_q
);

    logic                     seq_busy, shift_en, mac_clear, mac_en, out_load;
    logic                     use_b, sub_b, cplx_ph;
    logic [CADDR_W-1:0]       coef_raddr;
    logic [STEP_W-1:0]        idx_a, idx_b;
    logic [SH_W-1:0]          lat_shift;
    logic [DEC_W-1:0]         lat_decim;
    logic signed [COEF_W-1:0] coef_rd;
    logic signed [SAMP_W-1:0] a_i, a_q, b_i, b_q, head_i, head_q;
    logic signed [OUT_W-1:0]  res_i, res_q;

    fir_sequencer #(
        .TAP_W(TAP_W), .DEC_W(DEC_W), .SH_W(SH_W),
        .CADDR_W(CADDR_W), .STEP_W(STEP_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cfg_mode(cfg_mode), .cfg_taps(cfg_taps),
        .cfg_decim(cfg_decim), .cfg_shift(cfg_shift),
        .in_ready(in_ready), .busy(seq_busy), .shift_en(shift_en),
        .mac_clear(mac_clear), .mac_en(mac_en), .out_load(out_load),
        .coef_raddr(coef_raddr), .idx_a(idx_a), .idx_b(idx_b),
        .use_b(use_b), .sub_b(sub_b), .cplx_ph(cplx_ph),
        .lat_shift(lat_shift), .lat_decim(lat_decim)
    );

    fir_coef_store #(.DEPTH(COEF_DEPTH), .COEF_W(COEF_W)) coef_i (
        .clk(clk), .we(coef_we), .waddr(coef_addr),
        .wdata(coef_wdata), .raddr(coef_raddr), .rdata(coef_rd)
    );

    fir_tap_line #(.SAMP_W(SAMP_W), .DEPTH(MAX_TAPS), .IDX_W(STEP_W)) line_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .din_i(in_i), .din_q(in_q), .idx_a(idx_a), .idx_b(idx_b),
        .a_i(a_i), .a_q(a_q), .b_i(b_i), .b_q(b_q),
        .head_i(head_i), .head_q(head_q)
    );

    fir_mac_sat #(
        .SAMP_W(SAMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
        .OUT_W(OUT_W), .SH_W(SH_W)
    ) mac_i (
        .clk(clk), .rst_n(rst_n), .clear(mac_clear), .en(mac_en),
        .load(out_load), .use_b(use_b), .sub_b(sub_b), .cplx_ph(cplx_ph),
        .coef(coef_rd), .a_i(a_i), .a_q(a_q), .b_i(b_i), .b_q(b_q),
        .shift(lat_shift), .out_valid(out_valid),
        .out_i(res_i), .out_q(res_q)
    );

    assign out_i = res_i;
    assign out_q = res_q;

endmodule

// File: rtl/fir_fold_decim_chk.sv
// Checker for fir_fold_decim: handshake, decimation count, strobe width
// and tap-line entry, bound into the top.
// Assumes: it sees the top's internal busy flag, head of line and
// latched configuration.
module fir_fold_decim_chk #(
    parameter int SAMP_W = 12,
    parameter int DEC_W  = 5,
    parameter int SH_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [SAMP_W-1:0] in_i,
    input logic [SAMP_W-1:0] in_q,
    input logic              out_valid,
    input logic              busy,
    input logic [SAMP_W-1:0] head_i,
    input logic [SAMP_W-1:0] head_q,
    input logic [DEC_W-1:0]  lat_decim,
    input logic [SH_W-1:0]   lat_shift
);

    logic             fire;
    logic [DEC_W:0]   acc_cnt;
    logic [DEC_W:0]   dec_eff;

    assign fire    = in_valid && in_ready;
    assign dec_eff = (lat_decim == '0) ? (DEC_W+1)'(1) : {1'b0, lat_decim};

    // Count accepted samples since the previous output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
        end else if (out_valid) begin
            acc_cnt <= fire ? (DEC_W+1)'(1) : '0;
        end else if (fire) begin
            acc_cnt <= acc_cnt + (DEC_W+1)'(1);
        end
    end

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);  // R7

    AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid && in_ready));  // R6

    AST_DECIM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (acc_cnt == dec_eff));  // R6

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);  // R10

    AST_NEWEST_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (head_i == $past(in_i) && head_q == $past(in_q)));  // R6

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(lat_shift) && $stable(lat_decim)));  // R7

endmodule

bind fir_fold_decim fir_fold_decim_chk #(
    .SAMP_W(SAMP_W), .DEC_W(DEC_W), .SH_W(SH_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .busy(seq_busy),
    .head_i(head_i), .head_q(head_q), .lat_decim(lat_decim),
    .lat_shift(lat_shift)
);

// File: tb/fir_fold_decim_tb_top.sv
module fir_fold_decim_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SAMP_W  = 12;
    localparam int COEF_W  = 22;
    localparam int OUT_W   = 16;
    localparam int TAP_W   = 8;
    localparam int DEC_W   = 5;
    localparam int SH_W    = 6;
    localparam int CADDR_W = 7;
    localparam longint OMAX = (64'sd1 <<< (OUT_W-1)) - 1;
    localparam longint OMIN = -(64'sd1 <<< (OUT_W-1));

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [SAMP_W-1:0]  in_i = '0, in_q = '0;
    logic [1:0]         cfg_mode = 2'd0;
    logic [TAP_W-1:0]   cfg_taps = TAP_W'(1);
    logic [DEC_W-1:0]   cfg_decim = DEC_W'(1);
    logic [SH_W-1:0]    cfg_shift = '0;
    logic               coef_we = 1'b0;
    logic [CADDR_W-1:0] coef_addr = '0;
    logic [COEF_W-1:0]  coef_wdata = '0;
    logic               out_valid;
    logic [OUT_W-1:0]   out_i, out_q;

    int n_checks = 0;
    int n_fail   = 0;
    int n_pulse  = 0;
    int n_hist   = 0;
    int hist_i [4096];
    int hist_q [4096];
    int cm [128];
    longint h_i [256];
    longint h_q [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    fir_fold_decim dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .cfg_mode(cfg_mode), .cfg_taps(cfg_taps),
        .cfg_decim(cfg_decim), .cfg_shift(cfg_shift), .coef_we(coef_we),
        .coef_addr(coef_addr), .coef_wdata(coef_wdata),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // Count output strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) n_pulse++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_hist = 0;
        n_pulse = 0;
    endtask

    task automatic wr_coef(input int addr, input int val);
        @(negedge clk);
        coef_we = 1'b1;
        coef_addr = CADDR_W'(addr);
        coef_wdata = COEF_W'(val);
        cm[addr] = val;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic push(input int vi, input int vq);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_i = SAMP_W'(vi);
        in_q = SAMP_W'(vq);
        @(negedge clk);
        in_valid = 1'b0;
        hist_i[n_hist] = vi;
        hist_q[n_hist] = vq;
        n_hist++;
    endtask

    // Expand the stored coefficients into a full impulse response.
    task automatic build_h(input int mode, input int n);
        for (int t = 0; t < 256; t++) begin
            h_i[t] = 0;
            h_q[t] = 0;
        end
        if (mode == 0) begin
            for (int t = 0; t < n; t++) h_i[t] = cm[t];
        end else if (mode == 3) begin
            for (int t = 0; t < n; t++) begin
                h_i[t] = cm[t];
                h_q[t] = cm[64 + t];
            end
        end else begin
            int m = n / 2;
            for (int j = 0; j < (n + 1) / 2; j++) begin
                h_i[m + j] = cm[j];
                if (n - 1 - m - j != m + j)
                    h_i[n - 1 - m - j] = (mode == 2) ? -cm[j] : cm[j];
            end
        end
    endtask

    function automatic longint clamp_sh(input longint v, input int sh);
        longint s = v >>> sh;
        if (s > OMAX) return OMAX;
        if (s < OMIN) return OMIN;
        return s;
    endfunction

    function automatic longint model(input int mode, input int n, input int sh, input bit lane_q);
        longint y = 0;
        for (int t = 0; t < n; t++) begin
            longint xi = (t < n_hist) ? longint'(hist_i[n_hist - 1 - t]) : 0;
            longint xq = (t < n_hist) ? longint'(hist_q[n_hist - 1 - t]) : 0;
            if (mode == 3) begin
                if (lane_q) y += h_i[t] * xq + h_q[t] * xi;
                else        y += h_i[t] * xi - h_q[t] * xq;
            end else begin
                y += h_i[t] * (lane_q ? xq : xi);
            end
        end
        return clamp_sh(y, sh);
    endfunction

    function automatic int rsamp();
        return int'($urandom_range(4095)) - 2048;
    endfunction

    // kind: 0 random small coefficients, 1 pass-through set, 2 large coefficients
    task automatic run_case(input int mode, input int n, input int r, input int sh,
                            input int nout, input int kind, input bit disturb, input string req);
        int ncoef;
        do_reset();
        cfg_mode  = 2'(mode);
        cfg_taps  = TAP_W'(n);
        cfg_decim = DEC_W'(r);
        cfg_shift = SH_W'(sh);
        ncoef = (mode == 1 || mode == 2) ? (n + 1) / 2 : n;
        for (int k = 0; k < ncoef; k++) begin
            int v;
            if (kind == 1)      v = (k == 0) ? 1 : 0;
            else if (kind == 2) v = int'($urandom_range(2097151)) - 1048576;
            else                v = int'($urandom_range(8191)) - 4096;
            wr_coef(k, v);
            if (mode == 3) wr_coef(64 + k, int'($urandom_range(8191)) - 4096);
        end
        build_h(mode, n);
        repeat (2) @(negedge clk);
        for (int o = 0; o < nout; o++) begin
            longint ei, eq;
            int w = 0;
            for (int s = 0; s < r; s++) push(rsamp(), rsamp());
            chk(in_ready == 1'b0, "R7 ready low after group", longint'(in_ready), 0);
            ei = model(mode, n, sh, 1'b0);
            eq = model(mode, n, sh, 1'b1);
            if (disturb) begin
                cfg_shift = SH_W'(sh + 3);
                cfg_taps  = TAP_W'(n + 2);
            end
            while (!out_valid && w < 5000) begin
                @(negedge clk);
                w++;
            end
            if (disturb) begin
                cfg_shift = SH_W'(sh);
                cfg_taps  = TAP_W'(n);
            end
            chk(out_valid == 1'b1, {req, " output strobe"}, longint'(out_valid), 1);
            chk(longint'($signed(out_i)) == ei, {req, " I lane"}, longint'($signed(out_i)), ei);
            chk(longint'($signed(out_q)) == eq, {req, " Q lane"}, longint'($signed(out_q)), eq);
            if (kind == 1) begin
                chk(longint'($signed(out_i)) == longint'(hist_i[n_hist-1]), "R9 pass-through",
                    longint'($signed(out_i)), longint'(hist_i[n_hist-1]));
            end
            @(negedge clk);
            chk(out_valid == 1'b0, "R10 one-cycle strobe", longint'(out_valid), 0);
        end
        chk(n_pulse == nout, "R6 outputs per group", n_pulse, nout);
    endtask

    initial begin
        void'($urandom(32'h0000_5EED));
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1 ready in reset", longint'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        chk(out_i == '0 && out_q == '0, "R1 outputs zero", longint'(out_i), 0);

        run_case(0, 7,   1, 8,  5, 0, 1'b0, "R2 asym");
        run_case(1, 8,   2, 10, 5, 0, 1'b0, "R3 sym even N");
        run_case(1, 9,   3, 10, 5, 0, 1'b0, "R3 sym odd N");
        run_case(2, 10,  1, 10, 5, 0, 1'b0, "R4 anti even N");
        run_case(2, 11,  4, 10, 5, 0, 1'b0, "R4 anti odd N");
        run_case(3, 5,   2, 10, 5, 0, 1'b0, "R5 complex");
        run_case(3, 64, 16, 12, 3, 0, 1'b0, "R5 complex 64 R6 decim16");
        run_case(1, 255, 16, 14, 3, 0, 1'b0, "R3 sym 255 taps");
        run_case(0, 16,  1, 0,  5, 1, 1'b0, "R9 bypass R1 decim");
        run_case(0, 4,  16, 0,  3, 1, 1'b0, "R9 bypass decim16");
        run_case(0, 6,   1, 0,  5, 2, 1'b0, "R8 saturation");
        run_case(2, 12,  2, 20, 4, 2, 1'b0, "R8 shift");
        run_case(1, 13,  2, 10, 4, 0, 1'b1, "R7 config held");
        for (int k = 0; k < 4; k++) begin
            int md = int'($urandom_range(3));
            int nn = (md == 3) ? int'($urandom_range(64, 1)) : int'($urandom_range(40, 2));
            int rr = int'($urandom_range(16, 1));
            string tag = (md == 0) ? "R2 random" : (md == 1) ? "R3 random" :
                         (md == 2) ? "R4 random" : "R5 random";
            run_case(md, nn, rr, int'($urandom_range(14, 10)), 4, 0, 1'b0, tag);
        end
        finish_run();
    end

endmodule